// File: doc/BRIEF.md
# Parallel PRBS Error Checker

This block measures the bit error rate of a pseudo-random binary sequence that arrives already deserialized into words of P bits, one word per clock. A local reference register runs the same lookahead next-state function as the parallel generator on the far end, so each clock it predicts the next P bits of the sequence and compares all of them against the received word. The number of mismatching bits in a word is found by a combinational population count and added to an error accumulator in one step. A second accumulator adds P for each checked word, so the ratio of the two gives the error rate.

The checker synchronizes itself. While hunting, it loads the reference register from the received bits. It declares lock once a run of consecutive received words matches its predictions. While locked, the reference runs free, and errors are counted. If too many errors fall inside a window of locked words, the checker returns to hunting and reseeds from the incoming data. Both accumulators saturate instead of wrapping, and a clear input zeroes them. Word alignment beyond P-bit framing is left to the upstream deserializer.

Top module: `prbs_err_checker`

## Requirements
- R1: After reset, `err_count` and `bit_count` are zero and `locked` is low.
- R2: While hunting, `locked` rises in the cycle after the edge that accepts the SYNC_WORDS-th consecutive valid word equal to the reference prediction. The window error tally and the word position in the window both restart at lock.
- R3: Word bit 0 is the earliest bit in time. The sequence obeys b[k] = XOR of b[k-t] over every t in 1..LFSR_W with TAPS bit t-1 set, and the result is inverted when XNOR_FB is 1. All P bits of a word are checked every clock.
- R4: While locked, each valid word adds to `err_count` the number of bit positions in which it differs from the reference prediction. The amount can be anywhere from 0 to P.
- R5: While locked, each valid word adds P to `bit_count`.
- R6: Neither counter changes in a cycle where `in_valid` is low, or where `locked` is low before the edge.
- R7: The locked words are grouped into windows of WIN_WORDS valid words. When the window error tally, including the current word, reaches LOSS_THRESH, `locked` falls after that edge. The word is still counted. The reference then reseeds from that word. A window that ends below the threshold resets the tally.
- R8: Both counters hold at all ones instead of wrapping.
- R9: `clear` zeroes both counters at the next edge. It takes priority over a count in the same cycle and does not affect lock.
- R10: The reference register never holds the forbidden state: all zeros with XOR feedback, all ones with XNOR feedback. A stream of words made only of the forbidden value never produces lock.
- R11: A cycle with `in_valid` low does not advance the reference. Checking resumes in alignment when the stream continues.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clear | input | 1 | Zeroes both counters |
| in_valid | input | 1 | The received word is valid this cycle |
| rx_word | input | WORD_W | Received word, bit 0 earliest |
| err_count | output | CNT_W | Saturating count of bit errors |
| bit_count | output | CNT_W | Saturating count of checked bits |
| locked | output | 1 | The reference is synchronized to the stream |

## Verification
The bench uses the 7-bit x^7+x^6+1 sequence with XOR feedback and 8-bit words. Because the word is wider than the register, a single clean word reseeds it fully. Lock needs 4 clean words, and the loss rule uses windows of 8 words with a threshold of 12 errors. The counters are 10 bits wide, so both reach saturation within about a thousand words. At one injected error per word, each window ends with 8 errors, which is below the threshold while the running total over several windows exceeds it. This exercises the window reset. Whole-word inversions cross the threshold within two words and force a loss of lock followed by reacquisition.

// File: rtl/prbs_chk_pkg.sv
package prbs_chk_pkg;

    localparam int unsigned MAX_WORD    = 64;
    localparam int unsigned ERR_FIELD_W = 7;

    typedef enum logic {
        SYNC_HUNT   = 1'b0,
        SYNC_LOCKED = 1'b1
    } sync_mode_e;

    typedef struct packed {
        logic                   clean;
        logic [ERR_FIELD_W-1:0] errs;
    } word_check_t;

    function automatic logic [ERR_FIELD_W-1:0] count_ones(input logic [MAX_WORD-1:0] v);
        logic [ERR_FIELD_W-1:0] n;
        n = '0;
        for (int i = 0; i < MAX_WORD; i++) begin
            n = n + ERR_FIELD_W'(v[i]);
        end
        return n;
    endfunction

endpackage

// File: rtl/prbs_ref_gen.sv
module prbs_ref_gen #(
    parameter int unsigned LFSR_W = 7,
    parameter logic [LFSR_W-1:0] TAPS = 7'h60,
    parameter int unsigned WORD_W = 8,
    parameter bit XNOR_FB = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              advance,
    input  logic              reseed,
    input  logic [WORD_W-1:0] rx_word,
    output logic [WORD_W-1:0] exp_word
);
    localparam logic [LFSR_W-1:0] FORBID = {LFSR_W{XNOR_FB}};

    logic [LFSR_W-1:0] state;
    logic [LFSR_W-1:0] run_state;
    logic [LFSR_W-1:0] seed_state;

    // lookahead: P serial steps unrolled, state[0] holds the newest bit
    always_comb begin
        logic [LFSR_W-1:0] walk;
        logic fb;
        walk = state;
        exp_word = '0;
        for (int k = 0; k < int'(WORD_W); k++) begin
            fb = (^(walk & TAPS)) ^ XNOR_FB;
            exp_word[k] = fb;
            walk = {walk[LFSR_W-2:0], fb};
        end
        run_state = walk;
    end

    // seeding: shift the received bits in, then step off the forbidden state
    always_comb begin
        logic [LFSR_W-1:0] walk;
        walk = state;
        for (int k = 0; k < int'(WORD_W); k++) begin
            walk = {walk[LFSR_W-2:0], rx_word[k]};
        end
        if (walk == FORBID) begin
            walk[0] = ~walk[0];
        end
        seed_state = walk;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ~FORBID;
        end else if (advance) begin
            state <= reseed ? seed_state : run_state;
        end
    end

    AST_REF_LEGAL: assert property (@(posedge clk) disable iff (rst)
        state != FORBID); // R10

    AST_HOLD_ON_IDLE: assert property (@(posedge clk) disable iff (rst)
        !advance |=> $stable(state)); // R11

endmodule

// File: rtl/prbs_sync_ctl.sv
module prbs_sync_ctl
    import prbs_chk_pkg::*;
#(
    parameter int unsigned SYNC_WORDS  = 4,
    parameter int unsigned WIN_WORDS   = 16,
    parameter int unsigned LOSS_THRESH = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        valid,
    input  word_check_t chk,
    output logic        locked,
    output logic        reseed
);
    localparam int unsigned RUN_W  = $clog2(SYNC_WORDS + 1);
    localparam int unsigned WIN_W  = $clog2(WIN_WORDS);
    localparam int unsigned WERR_W = $clog2(LOSS_THRESH + MAX_WORD + 1);

    sync_mode_e         mode;
    logic [RUN_W-1:0]   clean_run;
    logic [WIN_W-1:0]   win_pos;
    logic [WERR_W-1:0]  win_err;
    logic [WERR_W-1:0]  win_sum;
    logic               lose;

    assign locked  = (mode == SYNC_LOCKED);
    assign win_sum = win_err + WERR_W'(chk.errs);
    assign lose    = locked && valid && (win_sum >= WERR_W'(LOSS_THRESH));
    assign reseed  = !locked || lose;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode      <= SYNC_HUNT;
            clean_run <= '0;
            win_pos   <= '0;
            win_err   <= '0;
        end else if (valid) begin
            case (mode)
                SYNC_HUNT: begin
                    if (!chk.clean) begin
                        clean_run <= '0;
                    end else if (clean_run == RUN_W'(SYNC_WORDS - 1)) begin
                        mode      <= SYNC_LOCKED;
                        clean_run <= '0;
                        win_pos   <= '0;
                        win_err   <= '0;
                    end else begin
                        clean_run <= clean_run + 1'b1;
                    end
                end
                SYNC_LOCKED: begin
                    if (lose) begin
                        mode      <= SYNC_HUNT;
                        clean_run <= '0;
                    end else if (win_pos == WIN_W'(WIN_WORDS - 1)) begin
                        win_pos <= '0;
                        win_err <= '0;
                    end else begin
                        win_pos <= win_pos + 1'b1;
                        win_err <= win_sum;
                    end
                end
                default: mode <= SYNC_HUNT;
            endcase
        end
    end

    AST_LOCK_ON_CLEAN: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> $past(valid && chk.clean)); // R2

    AST_DROP_ON_ERRORS: assert property (@(posedge clk) disable iff (rst)
        $fell(locked) |-> $past(valid && !chk.clean)); // R7

    AST_TALLY_BELOW_LIMIT: assert property (@(posedge clk) disable iff (rst)
        locked |-> (win_err < WERR_W'(LOSS_THRESH))); // R7

endmodule

// File: rtl/prbs_sat_acc.sv
module prbs_sat_acc #(
    parameter int unsigned CNT_W = 32,
    parameter int unsigned INC_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             inc_en,
    input  logic [INC_W-1:0] inc,
    output logic [CNT_W-1:0] count
);
    localparam int unsigned SUM_W = CNT_W + 1;

    logic [SUM_W-1:0] sum;
    logic [CNT_W-1:0] next_val;

    assign sum      = {1'b0, count} + SUM_W'(inc);
    assign next_val = sum[CNT_W] ? '1 : sum[CNT_W-1:0];

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            count <= '0;
        end else if (inc_en) begin
            count <= next_val;
        end
    end

    AST_SAT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!clear && (count == '1)) |=> (count == '1)); // R8

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        !clear |=> (count >= $past(count))); // R8

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
        clear |=> (count == '0)); // R9

    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!clear && !inc_en) |=> $stable(count)); // R6

endmodule

// File: rtl/prbs_err_checker.sv
module prbs_err_checker
    import prbs_chk_pkg::*;
#(
    parameter int unsigned LFSR_W      = 7,
    parameter logic [LFSR_W-1:0] TAPS  = 7'h60,
    parameter int unsigned WORD_W      = 8,
    parameter bit XNOR_FB              = 1'b0,
    parameter int unsigned SYNC_WORDS  = 4,
    parameter int unsigned WIN_WORDS   = 16,
    parameter int unsigned LOSS_THRESH = 8,
    parameter int unsigned CNT_W       = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] rx_word,
    output logic [CNT_W-1:0]  err_count,
    output logic [CNT_W-1:0]  bit_count,
    output logic              locked
);
    localparam int unsigned BITS_INC_W = $clog2(WORD_W + 1);

    logic [WORD_W-1:0]   exp_word;
    logic [WORD_W-1:0]   err_vec;
    logic [MAX_WORD-1:0] err_ext;
    word_check_t         chk;
    logic                reseed;
    logic                count_en;

    prbs_ref_gen #(
        .LFSR_W (LFSR_W),
        .TAPS   (TAPS),
        .WORD_W (WORD_W),
        .XNOR_FB(XNOR_FB)
    ) u_ref (
        .clk     (clk),
        .rst     (rst),
        .advance (in_valid),
        .reseed  (reseed),
        .rx_word (rx_word),
        .exp_word(exp_word)
    );

    assign err_vec = rx_word ^ exp_word;

    always_comb begin
        err_ext = '0;
        err_ext[WORD_W-1:0] = err_vec;
        chk.errs  = count_ones(err_ext);
        chk.clean = (err_vec == '0);
    end

    prbs_sync_ctl #(
        .SYNC_WORDS (SYNC_WORDS),
        .WIN_WORDS  (WIN_WORDS),
        .LOSS_THRESH(LOSS_THRESH)
    ) u_sync (
        .clk   (clk),
        .rst   (rst),
        .valid (in_valid),
        .chk   (chk),
        .locked(locked),
        .reseed(reseed)
    );

    assign count_en = locked && in_valid;

    prbs_sat_acc #(
        .CNT_W(CNT_W),
        .INC_W(ERR_FIELD_W)
    ) u_err_acc (
        .clk   (clk),
        .rst   (rst),
        .clear (clear),
        .inc_en(count_en),
        .inc   (chk.errs),
        .count (err_count)
    );

    prbs_sat_acc #(
        .CNT_W(CNT_W),
        .INC_W(BITS_INC_W)
    ) u_bit_acc (
        .clk   (clk),
        .rst   (rst),
        .clear (clear),
        .inc_en(count_en),
        .inc   (BITS_INC_W'(WORD_W)),
        .count (bit_count)
    );

endmodule

// File: tb/prbs_err_checker_test.sv
module prbs_err_checker_test;

    localparam int          W    = 7;
    localparam logic [6:0]  TP   = 7'h60;
    localparam int          P    = 8;
    localparam int          SYNC = 4;
    localparam int          WIN  = 8;
    localparam int          THR  = 12;
    localparam int          CW   = 10;
    localparam int          SATV = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          clear = 1'b0;
    logic          in_valid = 1'b0;
    logic [P-1:0]  rx_word = '0;
    logic [CW-1:0] err_count;
    logic [CW-1:0] bit_count;
    logic          locked;

    int checks = 0;
    int failures = 0;
    bit started = 1'b0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    prbs_err_checker #(
        .LFSR_W(W), .TAPS(TP), .WORD_W(P), .XNOR_FB(1'b0),
        .SYNC_WORDS(SYNC), .WIN_WORDS(WIN), .LOSS_THRESH(THR), .CNT_W(CW)
    ) uut (
        .clk(clk), .rst(rst), .clear(clear), .in_valid(in_valid),
        .rx_word(rx_word), .err_count(err_count), .bit_count(bit_count),
        .locked(locked)
    );

    // ---------------- transmit side: serial recurrence on a bit queue
    bit tx_hist[$];

    function automatic bit next_bit(ref bit h[$]);
        bit fb = 1'b0;
        for (int t = 1; t <= W; t++) begin
            if (TP[t-1]) fb = fb ^ h[t-1];
        end
        return fb;
    endfunction

    function automatic logic [P-1:0] tx_next_word();
        logic [P-1:0] w;
        for (int k = 0; k < P; k++) begin
            bit b = next_bit(tx_hist);
            w[k] = b;
            tx_hist.push_front(b);
            void'(tx_hist.pop_back());
        end
        return w;
    endfunction

    // ---------------- behavioural reference of the checker
    bit m_hist[$];
    bit m_locked;
    int m_run, m_win, m_werr, m_err, m_bits;

    function automatic logic [P-1:0] m_predict();
        bit h[$];
        logic [P-1:0] w;
        h = m_hist;
        for (int k = 0; k < P; k++) begin
            bit b = next_bit(h);
            w[k] = b;
            h.push_front(b);
            void'(h.pop_back());
        end
        return w;
    endfunction

    function automatic void m_shift_in(logic [P-1:0] w, bit fix);
        bit allz = 1'b1;
        for (int k = 0; k < P; k++) begin
            m_hist.push_front(w[k]);
            void'(m_hist.pop_back());
        end
        foreach (m_hist[i]) if (m_hist[i]) allz = 1'b0;
        if (fix && allz) m_hist[0] = 1'b1;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_hist = {};
            for (int i = 0; i < W; i++) m_hist.push_back(1'b1);
            m_locked = 0; m_run = 0; m_win = 0; m_werr = 0; m_err = 0; m_bits = 0;
        end else begin
            logic [P-1:0] pred;
            int e;
            bit was_locked;
            pred = m_predict();
            e = $countones(rx_word ^ pred);
            was_locked = m_locked;
            if (clear) begin
                m_err = 0; m_bits = 0;
            end else if (was_locked && in_valid) begin
                m_err  = (m_err + e > SATV) ? SATV : m_err + e;
                m_bits = (m_bits + P > SATV) ? SATV : m_bits + P;
            end
            if (in_valid) begin
                if (!was_locked) begin
                    m_shift_in(rx_word, 1'b1);
                    if (e == 0) begin
                        m_run++;
                        if (m_run == SYNC) begin
                            m_locked = 1; m_run = 0; m_win = 0; m_werr = 0;
                        end
                    end else begin
                        m_run = 0;
                    end
                end else if (m_werr + e >= THR) begin
                    m_locked = 0; m_run = 0;
                    m_shift_in(rx_word, 1'b1);
                end else begin
                    m_shift_in(pred, 1'b0);
                    if (m_win == WIN - 1) begin
                        m_win = 0; m_werr = 0;
                    end else begin
                        m_win++; m_werr += e;
                    end
                end
            end
        end
    end

    task automatic check_eq(string tag, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // per-cycle comparison against the reference
    always @(negedge clk) begin
        if (started && !rst && !finished) begin
            check_eq("R2", "locked", locked, m_locked);
            check_eq("R4", "err_count", err_count, m_err);
            check_eq("R5", "bit_count", bit_count, m_bits);
        end
    end

    task automatic send(logic [P-1:0] w);
        @(negedge clk);
        in_valid = 1'b1;
        rx_word  = w;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            rx_word  = 8'h5A;
        end
    endtask

    int e0, b0;

    initial begin
        for (int i = 0; i < W; i++) tx_hist.push_back(1'b1);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        started = 1'b1;
        // R1: reset values
        check_eq("R1", "err_count", err_count, 0);
        check_eq("R1", "bit_count", bit_count, 0);
        check_eq("R1", "locked", locked, 0);

        // R10: forbidden-value stream never locks
        for (int i = 0; i < 20; i++) send('0);
        idle(1);
        check_eq("R10", "locked on zeros", locked, 0);

        // R2 R3: clean stream locks
        for (int i = 0; i < 10; i++) send(tx_next_word());
        idle(1);
        check_eq("R2", "locked after clean run", locked, 1);
        check_eq("R3", "no errors on aligned stream", err_count, 0);

        // R4: single and multi-bit injections
        e0 = err_count;
        send(tx_next_word() ^ 8'h01);
        idle(1);
        check_eq("R4", "single-bit error", err_count, e0 + 1);
        send(tx_next_word() ^ 8'hA5);
        idle(1);
        check_eq("R4", "four-bit error", err_count, e0 + 5);
        send(tx_next_word() ^ 8'h0E);
        send(tx_next_word());
        idle(1);
        check_eq("R4", "three-bit error then clean", err_count, e0 + 8);

        // R5: bit accumulation
        b0 = bit_count;
        for (int i = 0; i < 3; i++) send(tx_next_word());
        idle(1);
        check_eq("R5", "three words", bit_count, b0 + 3 * P);

        // R6 R11: idle cycles change nothing; stream resumes aligned
        e0 = err_count; b0 = bit_count;
        idle(6);
        check_eq("R6", "err_count idle", err_count, e0);
        check_eq("R6", "bit_count idle", bit_count, b0);
        for (int i = 0; i < 4; i++) begin
            send(tx_next_word());
            idle(2);
        end
        check_eq("R11", "no errors after gaps", err_count, e0);
        check_eq("R11", "still locked", locked, 1);

        // R9: clear beats an errored word in the same cycle
        send(tx_next_word() ^ 8'h03);
        clear = 1'b1;
        idle(1);
        clear = 1'b0;
        check_eq("R9", "err_count cleared", err_count, 0);
        check_eq("R9", "bit_count cleared", bit_count, 0);
        check_eq("R9", "lock kept", locked, 1);

        // R7: inverted words cross the window threshold
        send(~tx_next_word());
        send(~tx_next_word());
        idle(1);
        check_eq("R7", "lock dropped", locked, 0);
        for (int i = 0; i < 8; i++) send(tx_next_word());
        idle(1);
        check_eq("R7", "relocked", locked, 1);

        // R8: bit counter saturation
        for (int i = 0; i < 140; i++) send(tx_next_word());
        idle(1);
        check_eq("R8", "bit_count saturated", bit_count, SATV);

        // R8 R7: one error per word, windows reset below threshold
        for (int i = 0; i < 1100; i++) send(tx_next_word() ^ (8'h01 << (i % P)));
        idle(1);
        check_eq("R8", "err_count saturated", err_count, SATV);
        check_eq("R7", "window reset keeps lock", locked, 1);
        for (int i = 0; i < 5; i++) send(tx_next_word() ^ 8'h10);
        idle(1);
        check_eq("R8", "err_count holds", err_count, SATV);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule